// File: doc/BRIEF.md
# Dual-Mode Panel Raster Timing Generator

This block produces the raster timing for a 640 x 480 flat panel driven from its dot clock (nominally 25.175 MHz, usable from 21 to 29 MHz). It generates active-low horizontal and vertical sync, a data-enable strobe, and the column and row of the pixel the upstream source should fetch. The source returns that pixel's colour on `rgb_in` in the same cycle. One register stage then presents it on `rgb_out`, and that stage also drives `de`, so both change on the same edge.

The sync pulse, back porch and front porch lengths are programmable on each axis. A new profile is taken only at a frame boundary, or at any time while the generator is disabled. A profile is accepted only when every length lies within the panel's limits. When `fixed_mode` is set, the profile must also place the first active pixel at the position a panel without a data-enable input assumes: sync plus back porch must be 144 clocks on a line and 33 lines in a frame. A rejected profile is dropped, and the last accepted one stays in force.

Vertical sync is updated one clock after the line start, so its edges never coincide with a horizontal sync edge.

Top module: `dot_timing_gen`

## Requirements
- R1: Each line lasts `hs+hbp+H_ACTIVE+hfp` clocks. `hsync_n` is low for `hs` clocks. `de` rises `hs+hbp` clocks after the falling edge of `hsync_n` and stays high for `H_ACTIVE` clocks.
- R2: Each frame lasts `vs+vbp+V_ACTIVE+vfp` lines. `vsync_n` is low for `vs` whole lines. `de` is active on `V_ACTIVE` consecutive lines, the first of them `vs+vbp` line starts after the line in which `vsync_n` falls.
- R3: `vsync_n` changes only one clock after the falling edge of `hsync_n`. It never changes in the same cycle as `hsync_n`.
- R4: A profile is accepted only if every field is in range: hsync 10..96, hbp 4..48, hfp 2..16 clocks; vsync 1..2, vbp 4..31, vfp 1..12 lines (all limits are parameters). Otherwise the previous profile is kept.
- R5: With `fixed_mode` high, a profile is accepted only if, in addition, hs+hbp equals H_FIX_SUM (144) and vs+vbp equals V_FIX_SUM (33). With `fixed_mode` low, these sums are not checked.
- R6: Configuration inputs are sampled only in the last cycle of a frame, or while `enable` is low. A change during a frame does not alter that frame.
- R7: `rgb_out` equals the `rgb_in` value presented one cycle earlier while `de` is high, and is zero while `de` is low. `de` and `rgb_out` are driven by the same register stage.
- R8: While the next cycle is active, `pix_x`/`pix_y` give the column (0..H_ACTIVE-1) and row (0..V_ACTIVE-1) of the pixel that `de` will present on the next edge. Otherwise they are zero.
- R9: From the first edge with `enable` low, all outputs are held low: `hsync_n`, `vsync_n`, `de`, `rgb_out`, `pix_x`, `pix_y`.
- R10: Reset drives every output low and loads the default profile (96/48/16 clocks, 2/31/12 lines). That profile stays in force while only invalid configurations are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low holds all outputs low |
| fixed_mode | input | 1 | Also require the fixed sync-plus-back-porch sums |
| cfg_hsync | input | HW (10) | Horizontal sync width in clocks |
| cfg_hbp | input | HW (10) | Horizontal back porch in clocks |
| cfg_hfp | input | HW (10) | Horizontal front porch in clocks |
| cfg_vsync | input | VW (10) | Vertical sync width in lines |
| cfg_vbp | input | VW (10) | Vertical back porch in lines |
| cfg_vfp | input | VW (10) | Vertical front porch in lines |
| rgb_in | input | 3*CW (18) | Colour of the pixel at pix_x/pix_y, red in the top field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on active pixels |
| rgb_out | output | 3*CW (18) | Registered pixel colour aligned with de |
| pix_x | output | XW (10) | Column to fetch |
| pix_y | output | YW (9) | Row to fetch |

## Verification
Horizontal sync and data enable follow the line counter through one register stage. Vertical sync follows one clock later, which puts its falling edge exactly one clock after that of horizontal sync. The pixel data arrives on the edge after its coordinate is shown. A new profile shows only in the frame after the one in which it was offered, so the bench waits two vertical sync falls after each change before it measures. A mid-frame change is checked against the frame then running, and against the next frame. All measurements are taken on the falling clock edge, as intervals between observed edges. No absolute cycle stamps are used, so the register latency of each output is counted exactly once.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC,
      SEG_BACK,
      SEG_ACT,
      SEG_FRONT
   } seg_e;

   // Segment of one raster axis that a position falls into.
   function automatic seg_e seg_of(input int unsigned pos,
                                   input int unsigned sync_len,
                                   input int unsigned bp_len,
                                   input int unsigned act_len);
      if (pos < sync_len)                 return SEG_SYNC;
      if (pos < sync_len + bp_len)        return SEG_BACK;
      if (pos < sync_len + bp_len + act_len) return SEG_ACT;
      return SEG_FRONT;
   endfunction

endpackage

// File: rtl/tgen_axis_chk.sv
// Validates one axis of a candidate profile against its limits.
module tgen_axis_chk #(
   parameter int unsigned W       = 10,
   parameter int unsigned SYNC_MIN = 10,
   parameter int unsigned SYNC_MAX = 96,
   parameter int unsigned BP_MIN  = 4,
   parameter int unsigned BP_MAX  = 48,
   parameter int unsigned FP_MIN  = 2,
   parameter int unsigned FP_MAX  = 16,
   parameter int unsigned FIX_SUM = 144
) (
   input  logic [W-1:0] sync_len,
   input  logic [W-1:0] bp_len,
   input  logic [W-1:0] fp_len,
   input  logic         fixed_mode,
   output logic         ok
);
   logic in_range;
   logic sum_ok;

   always_comb begin
      in_range = (32'(sync_len) >= SYNC_MIN) && (32'(sync_len) <= SYNC_MAX) &&
                 (32'(bp_len)   >= BP_MIN)   && (32'(bp_len)   <= BP_MAX)   &&
                 (32'(fp_len)   >= FP_MIN)   && (32'(fp_len)   <= FP_MAX);
      sum_ok   = (32'(sync_len) + 32'(bp_len)) == FIX_SUM;
      ok       = in_range && (!fixed_mode || sum_ok);
   end
endmodule

// File: rtl/tgen_scan.sv
// Profile shadow registers and the line / frame counters.
module tgen_scan #(
   parameter int unsigned HW       = 10,
   parameter int unsigned VW       = 10,
   parameter int unsigned H_ACTIVE = 640,
   parameter int unsigned V_ACTIVE = 480,
   parameter int unsigned DEF_HS   = 96,
   parameter int unsigned DEF_HBP  = 48,
   parameter int unsigned DEF_HFP  = 16,
   parameter int unsigned DEF_VS   = 2,
   parameter int unsigned DEF_VBP  = 31,
   parameter int unsigned DEF_VFP  = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          load_ok,
   input  logic [HW-1:0] cfg_hs,
   input  logic [HW-1:0] cfg_hbp,
   input  logic [HW-1:0] cfg_hfp,
   input  logic [VW-1:0] cfg_vs,
   input  logic [VW-1:0] cfg_vbp,
   input  logic [VW-1:0] cfg_vfp,
   output logic [HW-1:0] h_cnt,
   output logic [VW-1:0] v_cnt,
   output logic [HW-1:0] sh_hs,
   output logic [HW-1:0] sh_hbp,
   output logic [VW-1:0] sh_vs,
   output logic [VW-1:0] sh_vbp
);
   logic [HW-1:0] sh_hfp;
   logic [VW-1:0] sh_vfp;
   logic [HW-1:0] h_last;
   logic [VW-1:0] v_last;
   logic          line_end;
   logic          frame_end;

   always_comb begin
      h_last    = sh_hs + sh_hbp + HW'(H_ACTIVE) + sh_hfp - HW'(1);
      v_last    = sh_vs + sh_vbp + VW'(V_ACTIVE) + sh_vfp - VW'(1);
      line_end  = (h_cnt == h_last);
      frame_end = line_end && (v_cnt == v_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt  <= '0;
         v_cnt  <= '0;
         sh_hs  <= HW'(DEF_HS);
         sh_hbp <= HW'(DEF_HBP);
         sh_hfp <= HW'(DEF_HFP);
         sh_vs  <= VW'(DEF_VS);
         sh_vbp <= VW'(DEF_VBP);
         sh_vfp <= VW'(DEF_VFP);
      end else begin
         if (!enable) begin
            h_cnt <= '0;
            v_cnt <= '0;
         end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= frame_end ? '0 : v_cnt + VW'(1);
         end else begin
            h_cnt <= h_cnt + HW'(1);
         end
         if ((!enable || frame_end) && load_ok) begin
            sh_hs  <= cfg_hs;
            sh_hbp <= cfg_hbp;
            sh_hfp <= cfg_hfp;
            sh_vs  <= cfg_vs;
            sh_vbp <= cfg_vbp;
            sh_vfp <= cfg_vfp;
         end
      end
   end

   // R6: profile only moves at a frame boundary while running
   p_prof_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !$past(frame_end)) |->
         ($stable(sh_hs) && $stable(sh_hbp) && $stable(sh_hfp) &&
          $stable(sh_vs) && $stable(sh_vbp) && $stable(sh_vfp)));

   // R1: the line counter never passes the end of the line
   p_line_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (h_cnt <= h_last));

   // R2: the frame counter never passes the end of the frame
   p_frame_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (v_cnt <= v_last));
endmodule

// File: rtl/tgen_out.sv
// Registered sync, data enable and pixel stage plus fetch coordinates.
module tgen_out
   import tgen_pkg::*;
#(
   parameter int unsigned HW       = 10,
   parameter int unsigned VW       = 10,
   parameter int unsigned XW       = 10,
   parameter int unsigned YW       = 9,
   parameter int unsigned CW       = 6,
   parameter int unsigned H_ACTIVE = 640,
   parameter int unsigned V_ACTIVE = 480
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic [HW-1:0]   h_cnt,
   input  logic [VW-1:0]   v_cnt,
   input  logic [HW-1:0]   sh_hs,
   input  logic [HW-1:0]   sh_hbp,
   input  logic [VW-1:0]   sh_vs,
   input  logic [VW-1:0]   sh_vbp,
   input  logic [3*CW-1:0] rgb_in,
   output logic            hsync_n,
   output logic            vsync_n,
   output logic            de,
   output logic [3*CW-1:0] rgb_out,
   output logic [XW-1:0]   pix_x,
   output logic [YW-1:0]   pix_y
);
   seg_e          hseg;
   seg_e          vseg;
   logic          act;
   logic [HW-1:0] h_first;
   logic [VW-1:0] v_first;

   always_comb begin
      hseg    = seg_of(32'(h_cnt), 32'(sh_hs), 32'(sh_hbp), H_ACTIVE);
      vseg    = seg_of(32'(v_cnt), 32'(sh_vs), 32'(sh_vbp), V_ACTIVE);
      act     = enable && (hseg == SEG_ACT) && (vseg == SEG_ACT);
      h_first = sh_hs + sh_hbp;
      v_first = sh_vs + sh_vbp;
      pix_x   = act ? XW'(h_cnt - h_first) : '0;
      pix_y   = act ? YW'(v_cnt - v_first) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_n <= 1'b0;
         vsync_n <= 1'b0;
         de      <= 1'b0;
         rgb_out <= '0;
      end else if (!enable) begin
         hsync_n <= 1'b0;
         vsync_n <= 1'b0;
         de      <= 1'b0;
         rgb_out <= '0;
      end else begin
         hsync_n <= (hseg != SEG_SYNC);
         // vertical edges move one clock behind the line start
         if (h_cnt == HW'(1)) vsync_n <= (vseg != SEG_SYNC);
         de      <= act;
         rgb_out <= act ? rgb_in : '0;
      end
   end

   // R3: the two syncs never move on the same edge while running
   p_sync_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> ($stable(vsync_n) || $stable(hsync_n)));

   // R3: a vertical sync fall comes one clock after a horizontal fall
   p_vs_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && $fell(vsync_n)) |->
         (!hsync_n && $past(hsync_n, 2)));

   // R9: disabled generator drives everything low
   p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!hsync_n && !vsync_n && !de && (rgb_out == '0)));

   // R7: no colour outside the enable window
   p_blank_rgb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (rgb_out == '0));
endmodule

// File: rtl/dot_timing_gen.sv
module dot_timing_gen #(
   parameter int unsigned H_ACTIVE  = 640,
   parameter int unsigned V_ACTIVE  = 480,
   parameter int unsigned CW        = 6,
   parameter int unsigned HS_MIN    = 10,
   parameter int unsigned HS_MAX    = 96,
   parameter int unsigned HBP_MIN   = 4,
   parameter int unsigned HBP_MAX   = 48,
   parameter int unsigned HFP_MIN   = 2,
   parameter int unsigned HFP_MAX   = 16,
   parameter int unsigned VS_MIN    = 1,
   parameter int unsigned VS_MAX    = 2,
   parameter int unsigned VBP_MIN   = 4,
   parameter int unsigned VBP_MAX   = 31,
   parameter int unsigned VFP_MIN   = 1,
   parameter int unsigned VFP_MAX   = 12,
   parameter int unsigned H_FIX_SUM = 144,
   parameter int unsigned V_FIX_SUM = 33,
   parameter int unsigned DEF_HS    = 96,
   parameter int unsigned DEF_HBP   = 48,
   parameter int unsigned DEF_HFP   = 16,
   parameter int unsigned DEF_VS    = 2,
   parameter int unsigned DEF_VBP   = 31,
   parameter int unsigned DEF_VFP   = 12,
   localparam int unsigned HW = $clog2(HS_MAX + HBP_MAX + H_ACTIVE + HFP_MAX + 1),
   localparam int unsigned VW = $clog2(VS_MAX + VBP_MAX + V_ACTIVE + VFP_MAX + 1),
   localparam int unsigned XW = $clog2(H_ACTIVE),
   localparam int unsigned YW = $clog2(V_ACTIVE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            fixed_mode,
   input  logic [HW-1:0]   cfg_hsync,
   input  logic [HW-1:0]   cfg_hbp,
   input  logic [HW-1:0]   cfg_hfp,
   input  logic [VW-1:0]   cfg_vsync,
   input  logic [VW-1:0]   cfg_vbp,
   input  logic [VW-1:0]   cfg_vfp,
   input  logic [3*CW-1:0] rgb_in,
   output logic            hsync_n,
   output logic            vsync_n,
   output logic            de,
   output logic [3*CW-1:0] rgb_out,
   output logic [XW-1:0]   pix_x,
   output logic [YW-1:0]   pix_y
);
   // elaboration-time parameter checks
   if (HS_MIN < 2) begin : g_bad_hs_min
      $error("hsync minimum must be at least 2 clocks");
   end
   if ((HS_MIN > HS_MAX) || (HBP_MIN > HBP_MAX) || (HFP_MIN > HFP_MAX) ||
       (VS_MIN > VS_MAX) || (VBP_MIN > VBP_MAX) || (VFP_MIN > VFP_MAX)) begin : g_bad_order
      $error("a range minimum exceeds its maximum");
   end
   if ((HFP_MIN < 1) || (VS_MIN < 1) || (H_ACTIVE < 2) || (V_ACTIVE < 2)) begin : g_bad_len
      $error("front porch, vsync and active lengths must be non-zero");
   end
   if ((DEF_HS < HS_MIN) || (DEF_HS > HS_MAX) || (DEF_HBP < HBP_MIN) || (DEF_HBP > HBP_MAX) ||
       (DEF_HFP < HFP_MIN) || (DEF_HFP > HFP_MAX) || (DEF_VS < VS_MIN) || (DEF_VS > VS_MAX) ||
       (DEF_VBP < VBP_MIN) || (DEF_VBP > VBP_MAX) || (DEF_VFP < VFP_MIN) ||
       (DEF_VFP > VFP_MAX)) begin : g_bad_default
      $error("default profile lies outside the limits");
   end

   logic          h_ok;
   logic          v_ok;
   logic          load_ok;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic [HW-1:0] sh_hs;
   logic [HW-1:0] sh_hbp;
   logic [VW-1:0] sh_vs;
   logic [VW-1:0] sh_vbp;

   tgen_axis_chk #(
      .W(HW), .SYNC_MIN(HS_MIN), .SYNC_MAX(HS_MAX), .BP_MIN(HBP_MIN), .BP_MAX(HBP_MAX),
      .FP_MIN(HFP_MIN), .FP_MAX(HFP_MAX), .FIX_SUM(H_FIX_SUM)
   ) u_hchk (
      .sync_len(cfg_hsync), .bp_len(cfg_hbp), .fp_len(cfg_hfp),
      .fixed_mode(fixed_mode), .ok(h_ok)
   );

   tgen_axis_chk #(
      .W(VW), .SYNC_MIN(VS_MIN), .SYNC_MAX(VS_MAX), .BP_MIN(VBP_MIN), .BP_MAX(VBP_MAX),
      .FP_MIN(VFP_MIN), .FP_MAX(VFP_MAX), .FIX_SUM(V_FIX_SUM)
   ) u_vchk (
      .sync_len(cfg_vsync), .bp_len(cfg_vbp), .fp_len(cfg_vfp),
      .fixed_mode(fixed_mode), .ok(v_ok)
   );

   assign load_ok = h_ok && v_ok;

   tgen_scan #(
      .HW(HW), .VW(VW), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
      .DEF_HS(DEF_HS), .DEF_HBP(DEF_HBP), .DEF_HFP(DEF_HFP),
      .DEF_VS(DEF_VS), .DEF_VBP(DEF_VBP), .DEF_VFP(DEF_VFP)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .enable(enable), .load_ok(load_ok),
      .cfg_hs(cfg_hsync), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
      .cfg_vs(cfg_vsync), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
      .h_cnt(h_cnt), .v_cnt(v_cnt),
      .sh_hs(sh_hs), .sh_hbp(sh_hbp), .sh_vs(sh_vs), .sh_vbp(sh_vbp)
   );

   tgen_out #(
      .HW(HW), .VW(VW), .XW(XW), .YW(YW), .CW(CW),
      .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .h_cnt(h_cnt), .v_cnt(v_cnt),
      .sh_hs(sh_hs), .sh_hbp(sh_hbp), .sh_vs(sh_vs), .sh_vbp(sh_vbp),
      .rgb_in(rgb_in),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .rgb_out(rgb_out),
      .pix_x(pix_x), .pix_y(pix_y)
   );

   // R4: a profile outside the limits is never in force while running
   p_prof_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> ((32'(sh_hs) >= HS_MIN) && (32'(sh_hs) <= HS_MAX) &&
                  (32'(sh_vs) >= VS_MIN) && (32'(sh_vs) <= VS_MAX)));
endmodule

// File: tb/dot_timing_gen_tb.sv
`timescale 1ns/1ps
module dot_timing_gen_tb;
   localparam int HA = 16;
   localparam int VA = 4;
   localparam int CW = 6;
   localparam int HW = $clog2(8 + 6 + HA + 4 + 1);
   localparam int VW = $clog2(2 + 4 + VA + 3 + 1);
   localparam int XW = $clog2(HA);
   localparam int YW = $clog2(VA);
   localparam int NV = 10;
   // hs, hbp, hfp, vs, vbp, vfp, fixed, accepted
   localparam int VEC [NV][8] = '{
      '{6, 4, 2, 1, 3, 2, 1, 1},
      '{2, 1, 1, 2, 1, 1, 0, 1},
      '{8, 6, 4, 2, 4, 3, 0, 1},
      '{9, 1, 2, 1, 1, 1, 0, 0},
      '{4, 6, 3, 1, 3, 1, 1, 1},
      '{5, 4, 2, 1, 3, 1, 1, 0},
      '{5, 4, 2, 1, 3, 1, 0, 1},
      '{3, 3, 3, 2, 2, 2, 0, 1},
      '{6, 4, 2, 1, 2, 2, 1, 0},
      '{4, 2, 0, 1, 1, 1, 0, 0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enable = 1'b0;
   logic            fixed_mode = 1'b0;
   logic [HW-1:0]   cfg_hsync = '0, cfg_hbp = '0, cfg_hfp = '0;
   logic [VW-1:0]   cfg_vsync = '0, cfg_vbp = '0, cfg_vfp = '0;
   logic [3*CW-1:0] rgb_in;
   logic            hsync_n, vsync_n, de;
   logic [3*CW-1:0] rgb_out;
   logic [XW-1:0]   pix_x;
   logic [YW-1:0]   pix_y;

   int n_chk = 0;
   int n_bad = 0;
   int e_hs, e_hbp, e_hfp, e_vs, e_vbp, e_vfp;
   int m_lp, m_hsw, m_deoff, m_derun, m_vslow, m_firstln, m_delines, m_frame, m_vsage;
   int m_r7err, m_r8err;

   always #4 clk = ~clk;

   // source: colour is a function of the requested coordinate
   assign rgb_in = {CW'(pix_y), CW'(pix_x), CW'(pix_x) ^ CW'(5)};

   dot_timing_gen #(
      .H_ACTIVE(HA), .V_ACTIVE(VA), .CW(CW),
      .HS_MIN(2), .HS_MAX(8), .HBP_MIN(1), .HBP_MAX(6), .HFP_MIN(1), .HFP_MAX(4),
      .VS_MIN(1), .VS_MAX(2), .VBP_MIN(1), .VBP_MAX(4), .VFP_MIN(1), .VFP_MAX(3),
      .H_FIX_SUM(10), .V_FIX_SUM(4),
      .DEF_HS(6), .DEF_HBP(4), .DEF_HFP(2), .DEF_VS(1), .DEF_VBP(3), .DEF_VFP(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fixed_mode(fixed_mode),
      .cfg_hsync(cfg_hsync), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
      .cfg_vsync(cfg_vsync), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
      .rgb_in(rgb_in), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
      .rgb_out(rgb_out), .pix_x(pix_x), .pix_y(pix_y)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic set_cfg(input int hs, hbp, hfp, vs, vbp, vfp, fx);
      cfg_hsync = HW'(hs); cfg_hbp = HW'(hbp); cfg_hfp = HW'(hfp);
      cfg_vsync = VW'(vs); cfg_vbp = VW'(vbp); cfg_vfp = VW'(vfp);
      fixed_mode = fx[0];
   endtask

   task automatic wait_vs_fall();
      logic p;
      do begin
         p = vsync_n;
         @(negedge clk);
      end while (!(p && !vsync_n));
   endtask

   // called on the sample where vsync_n has just fallen; runs to the next fall
   task automatic measure();
      int c = 0, lines = 0, last_hf = -1, px = 0;
      logic ph = hsync_n, pd = de, pv = vsync_n;
      logic vs_done = 1'b0;
      logic [3*CW-1:0] ex;
      m_lp = -1; m_hsw = -1; m_deoff = -1; m_derun = -1; m_vslow = 1;
      m_firstln = -1; m_delines = 0; m_frame = -1; m_r7err = 0; m_r8err = 0;
      while (c < 5000) begin
         @(negedge clk);
         c++;
         if (ph && !hsync_n) begin
            lines++;
            if (lines == 2) m_lp = c - last_hf;
            last_hf = c;
         end
         if (!ph && hsync_n && lines >= 1 && m_hsw < 0) m_hsw = c - last_hf;
         if (!vsync_n && !vs_done) m_vslow++;
         else vs_done = 1'b1;
         if (!pd && de) begin
            m_delines++;
            px = 0;
            if (m_firstln < 0) begin
               m_firstln = lines;
               m_deoff = c - last_hf;
            end
         end
         if (pd && !de && m_delines == 1) m_derun = px;
         if (de) begin
            ex = {CW'(m_delines - 1), CW'(px), CW'(px) ^ CW'(5)};
            if (rgb_out[3*CW-1:CW] != ex[3*CW-1:CW]) m_r8err++;
            if (rgb_out[CW-1:0] != ex[CW-1:0]) m_r7err++;
            px++;
         end else if (rgb_out != '0) begin
            m_r7err++;
         end
         if (pv && !vsync_n) begin
            m_frame = c;
            m_vsage = c - last_hf;
            break;
         end
         ph = hsync_n; pd = de; pv = vsync_n;
      end
   endtask

   task automatic check_frame(input string ctx);
      int ht = e_hs + e_hbp + HA + e_hfp;
      int vt = e_vs + e_vbp + VA + e_vfp;
      chk({"R1 line period ", ctx}, m_lp, ht);
      chk({"R1 hsync width ", ctx}, m_hsw, e_hs);
      chk({"R1 de offset ", ctx}, m_deoff, e_hs + e_hbp);
      chk({"R1 de length ", ctx}, m_derun, HA);
      chk({"R2 vsync low clocks ", ctx}, m_vslow, e_vs * ht);
      chk({"R2 first active line ", ctx}, m_firstln, e_vs + e_vbp);
      chk({"R2 active lines ", ctx}, m_delines, VA);
      chk({"R2 frame period ", ctx}, m_frame, ht * vt);
      chk({"R3 vsync lag ", ctx}, m_vsage, 1);
      chk({"R7 data alignment/blank ", ctx}, m_r7err, 0);
      chk({"R8 coordinates ", ctx}, m_r8err, 0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      // R10: reset state, invalid cfg offered so defaults must stay
      set_cfg(0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk("R10 outputs low in reset",
          int'(hsync_n | vsync_n | de | (|rgb_out) | (|pix_x) | (|pix_y)), 0);
      rst_n = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      e_hs = 6; e_hbp = 4; e_hfp = 2; e_vs = 1; e_vbp = 3; e_vfp = 2;
      wait_vs_fall();
      measure();
      check_frame("R10 default profile");

      // table walk: R4 ranges, R5 fixed-mode sums
      for (int i = 0; i < NV; i++) begin
         set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);
         if (VEC[i][7] != 0) begin
            e_hs = VEC[i][0]; e_hbp = VEC[i][1]; e_hfp = VEC[i][2];
            e_vs = VEC[i][3]; e_vbp = VEC[i][4]; e_vfp = VEC[i][5];
         end
         wait_vs_fall();
         wait_vs_fall();
         measure();
         check_frame($sformatf("vec%0d %s", i, (VEC[i][6] != 0) ? "R5" : "R4"));
      end

      // R9: disable holds every output low
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      begin
         int bad = 0;
         for (int k = 0; k < 40; k++) begin
            if (hsync_n | vsync_n | de | (|rgb_out) | (|pix_x) | (|pix_y)) bad++;
            @(negedge clk);
         end
         chk("R9 outputs low while disabled", bad, 0);
      end
      enable = 1'b1;
      wait_vs_fall();
      measure();
      check_frame("R9 after re-enable");

      // R6: change in mid-frame only shows in the next frame
      wait_vs_fall();
      set_cfg(6, 4, 2, 1, 3, 2, 0);
      measure();
      check_frame("R6 current frame keeps old profile");
      e_hs = 6; e_hbp = 4; e_hfp = 2; e_vs = 1; e_vbp = 3; e_vfp = 2;
      measure();
      check_frame("R6 next frame takes new profile");

      summary();
      $finish;
   end
endmodule